// File: doc/BRIEF.md
# Interrupt Status and Soft Reset Register Block

This block holds the interrupt bookkeeping of a two-wire serial bus master controller as a small set of 16-bit registers. Seven single-cycle event pulses from the protocol engine set sticky status bits. Those bits are arbitration lost, missing acknowledge, access ready (transfer complete), receive ready, transmit ready, receive draining and transmit draining. Software clears a bit by writing a one to it. A mask, changed only through one register that sets bits and another that clears them, selects which events reach the single interrupt line. A raw view shows every event bit without the mask and also the bus-busy flag. Two pulses, START seen and STOP seen, keep that flag up to date.

The same block holds the controller's control word and a soft reset handshake. A write of the soft-reset bit in the system-config register returns every other register to its default. The reset-done flag then stays low until software sets the module-enable bit of the control word and a fixed number of cycles has passed. Register reads are combinational from the address; writes take effect at the next rising clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After the reset input is released, every register reads 0 and `irq` is low, except the system-status register (address 6), which reads 0x0001 (reset done in bit 0).
- R2: A pulse on `evt_pulse[i]` sets bit i of the raw status register (address 2), and the bit stays set afterwards. The bit order is: 0 arbitration lost, 1 no acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 receive draining, 6 transmit draining.
- R3: A write to the status register (address 1) clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R4: If an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit is set afterwards.
- R5: A write to address 3 sets the mask bits where the data is 1. A write to address 4 clears the mask bits where the data is 1. Both addresses read back the mask.
- R6: Address 1 reads the raw status ANDed with the mask. `irq` is high exactly when that masked value is nonzero.
- R7: A `bus_start` pulse sets the bus-busy flag in raw-status bit 12, and a `bus_stop` pulse clears it. When both pulse together the flag is set. The flag never appears at address 1 and never raises `irq`.
- R8: The control register (address 0) keeps only bit 15 (module enable), bit 10 (master), bit 9 (transmitter), bit 1 (STOP request) and bit 0 (START request). All its other bits read 0.
- R9: A write to the system-config register (address 5) with bit 1 set starts a soft reset. It clears the control, status, mask and bus-busy state and drops reset-done. The other bits of address 5 keep the written value, and bit 1 reads 1 while the reset is pending.
- R10: Reset-done rises exactly RST_CYCLES clock edges after the edge that writes module enable during a pending soft reset, and bit 1 of address 5 returns to 0 then. Without module enable, reset-done never rises.
- R11: A soft-reset write wins over an event pulse in the same cycle: the raw status is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| evt_pulse | input | 7 | Single-cycle event pulses from the protocol engine |
| bus_start | input | 1 | Pulse when a START condition is seen on the bus |
| bus_stop | input | 1 | Pulse when a STOP condition is seen on the bus |
| irq | output | 1 | Interrupt request, OR of the masked status bits |

## Verification
Two pairs of functions can land in the same cycle. In the first, an event pulse sets a status bit while software writes a one to clear that bit. In the second, a soft-reset write arrives while an event pulse is in flight. The bench provokes both by driving the pulse and the write in the same cycle. It then reads the raw status register: a set event must have survived the clear, and the soft reset must have wiped the event. The START-and-STOP-together case on the busy flag is judged the same way.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
   localparam logic [ADDR_W-1:0] A_STAT    = 4'd1;
   localparam logic [ADDR_W-1:0] A_RAW     = 4'd2;
   localparam logic [ADDR_W-1:0] A_EN_SET  = 4'd3;
   localparam logic [ADDR_W-1:0] A_EN_CLR  = 4'd4;
   localparam logic [ADDR_W-1:0] A_SYSCFG  = 4'd5;
   localparam logic [ADDR_W-1:0] A_SYSSTAT = 4'd6;

   // control word bit positions
   localparam int CB_ENABLE = 15;
   localparam int CB_MASTER = 10;
   localparam int CB_TX     = 9;
   localparam int CB_STOP   = 1;
   localparam int CB_START  = 0;

   // system register bit positions
   localparam int SB_SRST   = 1;
   localparam int SB_DONE   = 0;

   // event order inside the status word
   typedef enum int {
      EV_ARB_LOST = 0,
      EV_NO_ACK   = 1,
      EV_ACC_RDY  = 2,
      EV_RX_RDY   = 3,
      EV_TX_RDY   = 4,
      EV_RX_DRAIN = 5,
      EV_TX_DRAIN = 6
   } evt_idx_e;
endpackage

// File: rtl/irq_event_regs.sv
module irq_event_regs #(
   parameter int NUM_EVT = 7,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               w1c_en,
   input  logic [NUM_EVT-1:0] w1c_data,
   input  logic               mset_en,
   input  logic               mclr_en,
   input  logic [NUM_EVT-1:0] mdata,
   output logic [NUM_EVT-1:0] raw_o,
   output logic [NUM_EVT-1:0] mask_o,
   output logic [NUM_EVT-1:0] masked_o,
   output logic               irq_o
);
   logic [NUM_EVT-1:0] raw_q;
   logic [NUM_EVT-1:0] mask_q;
   logic [NUM_EVT-1:0] clr_bits;
   logic               any_hit;

   assign clr_bits = w1c_en ? w1c_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        raw_q <= '0;
      else if (soft_clr) raw_q <= '0;
      else               raw_q <= (raw_q & ~clr_bits) | evt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q <= '0;
      else if (soft_clr) mask_q <= '0;
      else if (mset_en)  mask_q <= mask_q | mdata;
      else if (mclr_en)  mask_q <= mask_q & ~mdata;
   end

   assign raw_o    = raw_q;
   assign mask_o   = mask_q;
   assign masked_o = raw_q & mask_q;
   assign any_hit  = |masked_o;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_hit;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = any_hit;
      end
   endgenerate
endmodule

// File: rtl/irq_bus_busy.sv
module irq_bus_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_clr,
   input  logic start_i,
   input  logic stop_i,
   output logic busy_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy_o <= 1'b0;
      else if (soft_clr) busy_o <= 1'b0;
      else if (start_i)  busy_o <= 1'b1;
      else if (stop_i)   busy_o <= 1'b0;
   end
endmodule

// File: rtl/irq_soft_reset.sv
module irq_soft_reset #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic enable_i,
   output logic pending_o,
   output logic done_o
);
   localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_o <= 1'b0;
         done_o    <= 1'b1;
         cnt_q     <= '0;
      end else if (start_i) begin
         pending_o <= 1'b1;
         done_o    <= 1'b0;
         cnt_q     <= '0;
      end else if (pending_o && enable_i) begin
         if (cnt_q == LAST) begin
            pending_o <= 1'b0;
            done_o    <= 1'b1;
            cnt_q     <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int NUM_EVT    = 7,
   parameter int BUSY_BIT   = 12,
   parameter int RST_CYCLES = 4,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic              bus_start,
   input  logic              bus_stop,
   output logic              irq
);
   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("DATA_W must be at least 16");
      end
      if (BUSY_BIT < NUM_EVT || BUSY_BIT >= DATA_W) begin : g_bad_busy
         $error("BUSY_BIT must lie above the event bits and inside DATA_W");
      end
      if (RST_CYCLES < 1) begin : g_bad_cycles
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0]  ctrl_q;
   logic [DATA_W-1:0]  syscfg_q;
   logic [DATA_W-1:0]  ctrl_keep;
   logic [NUM_EVT-1:0] raw_bits;
   logic [NUM_EVT-1:0] mask_bits;
   logic [NUM_EVT-1:0] masked_bits;
   logic               busy;
   logic               srst_pending;
   logic               rst_done;
   logic               soft_start;
   logic               wr_ctrl, wr_stat, wr_mset, wr_mclr, wr_cfg;

   assign wr_ctrl    = reg_wr && (reg_addr == A_CTRL);
   assign wr_stat    = reg_wr && (reg_addr == A_STAT);
   assign wr_mset    = reg_wr && (reg_addr == A_EN_SET);
   assign wr_mclr    = reg_wr && (reg_addr == A_EN_CLR);
   assign wr_cfg     = reg_wr && (reg_addr == A_SYSCFG);
   assign soft_start = wr_cfg && reg_wdata[SB_SRST];

   always_comb begin
      ctrl_keep            = '0;
      ctrl_keep[CB_ENABLE] = 1'b1;
      ctrl_keep[CB_MASTER] = 1'b1;
      ctrl_keep[CB_TX]     = 1'b1;
      ctrl_keep[CB_STOP]   = 1'b1;
      ctrl_keep[CB_START]  = 1'b1;
   end

   // control word: cleared by soft reset, write keeps defined bits only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctrl_q <= '0;
      else if (soft_start) ctrl_q <= '0;
      else if (wr_ctrl)    ctrl_q <= reg_wdata & ctrl_keep;
   end

   // system config: survives soft reset, reset bit not stored
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      syscfg_q <= '0;
      else if (wr_cfg) syscfg_q <= reg_wdata & ~(DATA_W'(1) << SB_SRST);
   end

   irq_event_regs #(
      .NUM_EVT (NUM_EVT),
      .IRQ_REG (IRQ_REG)
   ) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_start),
      .evt_i    (evt_pulse),
      .w1c_en   (wr_stat),
      .w1c_data (reg_wdata[NUM_EVT-1:0]),
      .mset_en  (wr_mset),
      .mclr_en  (wr_mclr),
      .mdata    (reg_wdata[NUM_EVT-1:0]),
      .raw_o    (raw_bits),
      .mask_o   (mask_bits),
      .masked_o (masked_bits),
      .irq_o    (irq)
   );

   irq_bus_busy u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_start),
      .start_i  (bus_start),
      .stop_i   (bus_stop),
      .busy_o   (busy)
   );

   irq_soft_reset #(
      .RST_CYCLES (RST_CYCLES)
   ) u_srst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (soft_start),
      .enable_i  (ctrl_q[CB_ENABLE]),
      .pending_o (srst_pending),
      .done_o    (rst_done)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:   reg_rdata = ctrl_q;
         A_STAT:   reg_rdata[NUM_EVT-1:0] = masked_bits;
         A_RAW: begin
            reg_rdata[NUM_EVT-1:0] = raw_bits;
            reg_rdata[BUSY_BIT]    = busy;
         end
         A_EN_SET, A_EN_CLR: reg_rdata[NUM_EVT-1:0] = mask_bits;
         A_SYSCFG: begin
            reg_rdata          = syscfg_q;
            reg_rdata[SB_SRST] = srst_pending;
         end
         A_SYSSTAT: reg_rdata[SB_DONE] = rst_done;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
   import irq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int NUM_EVT = 7,
   parameter bit IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic               bus_start,
   input logic               irq,
   input logic [NUM_EVT-1:0] raw_q,
   input logic [NUM_EVT-1:0] mask_q,
   input logic               busy_q,
   input logic               ctrl_en,
   input logic [DATA_W-1:0]  ctrl_q,
   input logic               done_q
);
   logic srst_wr;
   assign srst_wr = reg_wr && (reg_addr == A_SYSCFG) && reg_wdata[SB_SRST];

   // R2 and R4: an event always lands in the raw status
   a_r4_event_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst_wr && evt_pulse != '0) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

   // R3: write-one-to-clear without competing events
   a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_STAT && evt_pulse == '0)
      |=> ((raw_q & $past(reg_wdata[NUM_EVT-1:0])) == '0));

   // R6: no mask, no interrupt
   a_r6_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && mask_q == '0) |-> !irq);

   // R7: START pulse makes the bus busy
   a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && !srst_wr) |=> busy_q);

   // R9: soft reset wipes the register state
   a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
      srst_wr |=> (ctrl_q == '0 && mask_q == '0 && raw_q == '0 && !busy_q && !done_q));

   // R10: reset-done rises only with module enable set
   a_r10_done_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(ctrl_en));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
   .DATA_W  (DATA_W),
   .NUM_EVT (NUM_EVT),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .evt_pulse (evt_pulse),
   .bus_start (bus_start),
   .irq       (irq),
   .raw_q     (raw_bits),
   .mask_q    (mask_bits),
   .busy_q    (busy),
   .ctrl_en   (ctrl_q[15]),
   .ctrl_q    (ctrl_q),
   .done_q    (rst_done)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [6:0]  evt_pulse = '0;
   logic        bus_start = 1'b0;
   logic        bus_stop = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_status_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_pulse (evt_pulse),
      .bus_start (bus_start),
      .bus_stop  (bus_stop),
      .irq       (irq)
   );

   // we, write addr, write data, {stop,start,evt[6:0]}, read addr, expected read, expected irq
   typedef struct packed {
      logic        we;
      logic [3:0]  wa;
      logic [15:0] wd;
      logic [8:0]  ev;
      logic [3:0]  ra;
      logic [15:0] exp;
      logic        xirq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 4'd0, 16'h0000, 9'h002, 4'd2, 16'h0002, 1'b0}, // R2 no-ack sets raw bit 1
      '{1'b0, 4'd0, 16'h0000, 9'h004, 4'd1, 16'h0000, 1'b0}, // R6 masked view empty
      '{1'b1, 4'd3, 16'h0004, 9'h000, 4'd1, 16'h0004, 1'b1}, // R5 R6 enable access-ready
      '{1'b1, 4'd1, 16'h0000, 9'h000, 4'd2, 16'h0006, 1'b1}, // R3 zero write no effect
      '{1'b1, 4'd1, 16'h0004, 9'h000, 4'd2, 16'h0002, 1'b0}, // R3 clear bit 2
      '{1'b1, 4'd3, 16'h007F, 9'h000, 4'd3, 16'h007F, 1'b1}, // R5 set all mask bits
      '{1'b1, 4'd4, 16'h0002, 9'h000, 4'd4, 16'h007D, 1'b0}, // R5 clear mask bit 1
      '{1'b1, 4'd1, 16'h0002, 9'h002, 4'd2, 16'h0002, 1'b0}, // R4 set beats clear
      '{1'b0, 4'd0, 16'h0000, 9'h048, 4'd1, 16'h0048, 1'b1}, // R6 two events masked in
      '{1'b1, 4'd1, 16'hFFFF, 9'h000, 4'd2, 16'h0000, 1'b0}, // R3 clear all
      '{1'b0, 4'd0, 16'h0000, 9'h080, 4'd2, 16'h1000, 1'b0}, // R7 start -> busy, no irq
      '{1'b1, 4'd0, 16'hFFFF, 9'h000, 4'd0, 16'h8603, 1'b0}, // R8 control bits kept
      '{1'b0, 4'd0, 16'h0000, 9'h100, 4'd2, 16'h0000, 1'b0}, // R7 stop clears busy
      '{1'b0, 4'd0, 16'h0000, 9'h180, 4'd2, 16'h1000, 1'b0}, // R7 start with stop -> busy
      '{1'b0, 4'd0, 16'h0000, 9'h100, 4'd1, 16'h0000, 1'b0}  // R7 busy never in masked view
   };

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic cycle(input logic we, input logic [3:0] wa, input logic [15:0] wd,
                        input logic [8:0] ev);
      @(negedge clk);
      reg_wr    = we;
      reg_addr  = wa;
      reg_wdata = wd;
      evt_pulse = ev[6:0];
      bus_start = ev[7];
      bus_stop  = ev[8];
      @(negedge clk);
      reg_wr    = 1'b0;
      evt_pulse = '0;
      bus_start = 1'b0;
      bus_stop  = 1'b0;
   endtask

   task automatic check_reg(input logic [3:0] ra, input logic [15:0] exp, input string req);
      reg_addr = ra;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         errors++;
         $display("FAIL %s addr %0d: got %h expected %h", req, ra, reg_rdata, exp);
      end
   endtask

   task automatic check_irq(input logic exp, input string req);
      checks++;
      if (irq !== exp) begin
         errors++;
         $display("FAIL %s irq: got %b expected %b", req, irq, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 6; a++) check_reg(4'(a), 16'h0000, "R1");
      check_reg(4'd6, 16'h0001, "R1");
      check_irq(1'b0, "R1");

      // table walk
      for (int i = 0; i < NV; i++) begin
         cycle(VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].ev);
         check_reg(VEC[i].ra, VEC[i].exp, $sformatf("vector %0d", i));
         check_irq(VEC[i].xirq, $sformatf("vector %0d", i));
      end

      // soft reset with event in the same cycle (R9, R11)
      cycle(1'b1, 4'd3, 16'h007F, 9'h000);
      cycle(1'b0, 4'd0, 16'h0000, 9'h082);
      cycle(1'b1, 4'd0, 16'h8600, 9'h000);
      check_irq(1'b1, "R6");
      cycle(1'b1, 4'd5, 16'h00F2, 9'h001);
      check_reg(4'd2, 16'h0000, "R11");
      check_reg(4'd0, 16'h0000, "R9");
      check_reg(4'd3, 16'h0000, "R9");
      check_reg(4'd6, 16'h0000, "R9");
      check_reg(4'd5, 16'h00F2, "R9");
      check_irq(1'b0, "R9");

      // R10 no enable -> never done
      repeat (8) @(negedge clk);
      check_reg(4'd6, 16'h0000, "R10");

      // R10 enable -> done after exactly 4 edges
      cycle(1'b1, 4'd0, 16'h8000, 9'h000);
      repeat (3) @(negedge clk);
      check_reg(4'd6, 16'h0000, "R10");
      @(negedge clk);
      check_reg(4'd6, 16'h0001, "R10");
      check_reg(4'd5, 16'h00F0, "R10");
      check_reg(4'd0, 16'h8000, "R8");

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule